// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block watches a stream of light readings and raises an interrupt when the light leaves a programmable band for long enough. The band has an upper and a lower edge. Each edge comes from an 8-bit value that forms the top byte of a 16-bit compare value, and its low byte is zero. A reading that lies strictly above the upper edge, or strictly below the lower edge, lies outside the band. A run counter counts consecutive outside readings. When the count reaches the persistence limit chosen by a 2-bit selector, the block sets a sticky flag and asks the open-drain interrupt pad to pull low.

The flag stays set until the host clears it. Two sources can clear it. One is a strobe from the register decoder, raised when software writes zero to the flag's bit. The other is a strobe from a dedicated clear command. If a clear and a new trigger land in the same cycle, the trigger wins. A reading counts only in a cycle where its valid strobe is high. The run counter stops at the selected limit, so while the light stays outside the band every further outside reading triggers again. Register decoding and the converter sit outside this block.

Top module: `lux_window_irq`

## Requirements
- R1: The upper compare value is `{thr_hi_i, 8'h00}` and the lower compare value is `{thr_lo_i, 8'h00}`. With `thr_hi_i`=FFh and `thr_lo_i`=00h, readings 0000h and FF00h are inside the band and FF01h is outside.
- R2: A reading is outside the band only when it is strictly greater than the upper compare value or strictly less than the lower compare value. A reading equal to either compare value is inside.
- R3: `persist_sel_i` picks the number of consecutive outside readings needed: 0 picks 1, 1 picks 4, 2 picks 8, 3 picks 16. The flag is 1 right after the clock edge that accepts the last reading of that run, and it is not set by any shorter run.
- R4: A valid inside reading sets the run count back to zero. A cycle with `sample_valid_i` low leaves the run count unchanged, whatever value `sample_i` carries.
- R5: Once set, the flag stays 1 through inside readings and idle cycles until a clear arrives.
- R6: A high `clr_flag_wr_i` or a high `clr_cmd_i` clears the flag at the next clock edge, unless R7 applies.
- R7: If a trigger and a clear happen in the same cycle, the flag is 1 after that edge.
- R8: `irq_drive_low_o` is 1 (the pad pulls low) exactly when the flag is 1, and is 0 (the pad is released) otherwise.
- R9: The run count stops at the selected limit. After a clear, while the run continues, the next valid outside reading sets the flag again at once.
- R10: After reset, the flag, the pad enable and the run count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid_i | input | 1 | Marks `sample_i` as a new reading |
| sample_i | input | READ_W (16) | Light reading |
| thr_hi_i | input | THR_W (8) | Top byte of the upper compare value |
| thr_lo_i | input | THR_W (8) | Top byte of the lower compare value |
| persist_sel_i | input | 2 | Persistence selector (1/4/8/16) |
| clr_flag_wr_i | input | 1 | Clear strobe from a zero written to the flag bit |
| clr_cmd_i | input | 1 | Clear strobe from the clear command |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_drive_low_o | output | 1 | Pull-low enable for the open-drain interrupt pad |

## Verification
The bench builds the block with its defaults: 16-bit readings and 8-bit threshold bytes. At that width the byte-aligned compare edges can be hit exactly, one count on either side, so the strict greater-than and less-than rules are tested at their boundaries. The bench runs all four persistence settings, up to the full run of 16 readings. It interrupts runs with inside readings and with idle cycles that carry outside values, and it sends a clear in the same cycle as a trigger while the run counter is stopped at its limit.

// File: rtl/lwi_pkg.sv
// Package: types and helpers shared by the window interrupt block.
// Assumes the persistence selector is two bits wide and its largest run is 16.
package lwi_pkg;
    localparam int PERSIST_SEL_W = 2;
    localparam int PERSIST_MAX   = 16;
    localparam int PERSIST_CNT_W = $clog2(PERSIST_MAX + 1);

    typedef logic [PERSIST_SEL_W-1:0] persist_sel_t;
    typedef logic [PERSIST_CNT_W-1:0] persist_cnt_t;

    // Maps the selector code to the number of consecutive readings required.
    function automatic persist_cnt_t persist_limit(persist_sel_t sel);
        case (sel)
            2'd0:    return persist_cnt_t'(1);
            2'd1:    return persist_cnt_t'(4);
            2'd2:    return persist_cnt_t'(8);
            default: return persist_cnt_t'(PERSIST_MAX);
        endcase
    endfunction
endpackage

// File: rtl/lwi_window_cmp.sv
// Window comparator: widens the two threshold bytes into full-width compare
// values (low part zero) and flags a reading outside the band.
// Assumes READ_W > THR_W and unsigned readings. Purely combinational.
module lwi_window_cmp #(
    parameter int READ_W = 16,
    parameter int THR_W  = 8
) (
    input  logic [READ_W-1:0] reading_i,
    input  logic [THR_W-1:0]  hi_byte_i,
    input  logic [THR_W-1:0]  lo_byte_i,
    output logic              outside_o
);
    localparam int PAD_W = READ_W - THR_W;

    logic [READ_W-1:0] hi_val;
    logic [READ_W-1:0] lo_val;

    // Build the compare values and test both edges strictly.
    always_comb begin
        hi_val    = {hi_byte_i, {PAD_W{1'b0}}};
        lo_val    = {lo_byte_i, {PAD_W{1'b0}}};
        outside_o = (reading_i > hi_val) || (reading_i < lo_val);
    end
endmodule

// File: rtl/lwi_persist_ctr.sv
// Persistence counter: counts consecutive valid outside readings, stops at
// the selected limit and reports a trigger on each accepted reading that
// completes (or extends) the run. Assumes a synchronous active-low reset.
module lwi_persist_ctr
    import lwi_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic         outside_i,
    input  persist_sel_t sel_i,
    output persist_cnt_t cnt_o,
    output logic         trigger_o
);
    persist_cnt_t limit;
    persist_cnt_t cnt_q;
    persist_cnt_t cnt_inc;

    // Next count for an outside reading, held at the limit.
    always_comb begin
        limit     = persist_limit(sel_i);
        cnt_inc   = (cnt_q >= limit) ? limit : cnt_q + persist_cnt_t'(1);
        trigger_o = valid_i && outside_i && (cnt_inc == limit);
    end

    // Run count register: advance, restart or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (valid_i)
            cnt_q <= outside_i ? cnt_inc : '0;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lwi_sticky_flag.sv
// Sticky flag: set by a trigger, cleared by either clear strobe; a trigger
// wins over a clear in the same cycle. Assumes a synchronous active-low reset.
module lwi_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_a_i,
    input  logic clr_b_i,
    output logic flag_o
);
    logic flag_q;

    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_a_i || clr_b_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/lux_window_irq.sv
// Top: threshold window interrupt with persistence filter for light readings.
// Produces a sticky flag and a pull-low enable for an open-drain pad.
// Assumes thresholds and selector are held stable by the register file.
module lux_window_irq
    import lwi_pkg::*;
#(
    parameter int READ_W = 16,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid_i,
    input  logic [READ_W-1:0] sample_i,
    input  logic [THR_W-1:0]  thr_hi_i,
    input  logic [THR_W-1:0]  thr_lo_i,
    input  logic [1:0]        persist_sel_i,
    input  logic              clr_flag_wr_i,
    input  logic              clr_cmd_i,
    output logic              irq_flag_o,
    output logic              irq_drive_low_o
);
    logic         out_of_win;
    logic         trigger;
    persist_cnt_t persist_cnt;

    lwi_window_cmp #(.READ_W(READ_W), .THR_W(THR_W)) u_cmp (
        .reading_i (sample_i),
        .hi_byte_i (thr_hi_i),
        .lo_byte_i (thr_lo_i),
        .outside_o (out_of_win)
    );

    lwi_persist_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (sample_valid_i),
        .outside_i (out_of_win),
        .sel_i     (persist_sel_i),
        .cnt_o     (persist_cnt),
        .trigger_o (trigger)
    );

    lwi_sticky_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (trigger),
        .clr_a_i (clr_flag_wr_i),
        .clr_b_i (clr_cmd_i),
        .flag_o  (irq_flag_o)
    );

    // The pad pulls low whenever the flag is set.
    assign irq_drive_low_o = irq_flag_o;
endmodule

// File: rtl/lwi_checker.sv
// Checker for lux_window_irq: temporal properties on flag, count and clears.
// Attached to every instance of the top through the bind below.
module lwi_checker
    import lwi_pkg::*;
#(
    parameter int READ_W = 16,
    parameter int THR_W  = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sample_valid_i,
    input logic [1:0]   persist_sel_i,
    input logic         clr_flag_wr_i,
    input logic         clr_cmd_i,
    input logic         irq_flag_o,
    input logic         irq_drive_low_o,
    input logic         out_of_win,
    input logic         trigger,
    input persist_cnt_t cnt
);
    logic clr_any;
    assign clr_any = clr_flag_wr_i || clr_cmd_i;

    // R3: the flag can only rise after an accepted outside reading.
    a_r3_rise_needs_outside: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag_o) |-> $past(sample_valid_i && out_of_win));

    // R4: an accepted inside reading restarts the run.
    a_r4_inside_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && !out_of_win) |=> (cnt == '0));

    // R4: idle cycles keep the run count.
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_i |=> $stable(cnt));

    // R5: without a clear the flag stays set.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !clr_any) |=> irq_flag_o);

    // R6: a clear with no trigger drops the flag.
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && !trigger) |=> !irq_flag_o);

    // R7: a trigger always leaves the flag set, clear or not.
    a_r7_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> irq_flag_o);

    // R8: the pad enable agrees with the flag.
    a_r8_pad_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_low_o == irq_flag_o);

    // R9: after an accepted reading under a steady selector, the count is at most the limit.
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sample_valid_i) && $stable(persist_sel_i))
            |-> (cnt <= persist_limit(persist_sel_i)));
endmodule

bind lux_window_irq lwi_checker #(.READ_W(READ_W), .THR_W(THR_W)) u_lwi_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_valid_i  (sample_valid_i),
    .persist_sel_i   (persist_sel_i),
    .clr_flag_wr_i   (clr_flag_wr_i),
    .clr_cmd_i       (clr_cmd_i),
    .irq_flag_o      (irq_flag_o),
    .irq_drive_low_o (irq_drive_low_o),
    .out_of_win      (out_of_win),
    .trigger         (trigger),
    .cnt             (persist_cnt)
);

// File: tb/tb_lux_window_irq.sv
module tb_lux_window_irq;
    localparam int READ_W = 16;
    localparam int THR_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid_i = 1'b0;
    logic [READ_W-1:0] sample_i = '0;
    logic [THR_W-1:0]  thr_hi_i = 8'hFF;
    logic [THR_W-1:0]  thr_lo_i = 8'h00;
    logic [1:0]        persist_sel_i = 2'd0;
    logic              clr_flag_wr_i = 1'b0;
    logic              clr_cmd_i = 1'b0;
    logic              irq_flag_o;
    logic              irq_drive_low_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    int model_cnt  = 0;
    bit model_flag = 1'b0;

    lux_window_irq #(.READ_W(READ_W), .THR_W(THR_W)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sample_valid_i  (sample_valid_i),
        .sample_i        (sample_i),
        .thr_hi_i        (thr_hi_i),
        .thr_lo_i        (thr_lo_i),
        .persist_sel_i   (persist_sel_i),
        .clr_flag_wr_i   (clr_flag_wr_i),
        .clr_cmd_i       (clr_cmd_i),
        .irq_flag_o      (irq_flag_o),
        .irq_drive_low_o (irq_drive_low_o)
    );

    always #5 clk = ~clk;

    function automatic int limit_of(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 16;
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected flag.
    task automatic step(input bit v, input logic [15:0] rd, input bit cw,
                        input bit cc, input string tag);
        bit outside;
        bit trig;
        int lim;
        @(negedge clk);
        sample_valid_i = v;
        sample_i       = rd;
        clr_flag_wr_i  = cw;
        clr_cmd_i      = cc;
        lim     = limit_of(persist_sel_i);
        outside = (rd > {thr_hi_i, 8'h00}) || (rd < {thr_lo_i, 8'h00});
        trig    = 1'b0;
        if (v) begin
            if (outside) begin
                model_cnt = (model_cnt >= lim) ? lim : model_cnt + 1;
                trig = (model_cnt == lim);
            end else begin
                model_cnt = 0;
            end
        end
        if (trig) model_flag = 1'b1;
        else if (cw || cc) model_flag = 1'b0;
        exp_q.push_back(model_flag);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'hFFFF, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compares flag and pad enable after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (irq_flag_o !== e || irq_drive_low_o !== e) begin
                    errors++;
                    $display("FAIL %s: flag=%0b pad=%0b expected %0b", t,
                             irq_flag_o, irq_drive_low_o, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (irq_flag_o !== 1'b0 || irq_drive_low_o !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: flag=%0b pad=%0b expected 0", irq_flag_o, irq_drive_low_o);
        end

        // R1: default bytes FFh/00h.
        step(1, 16'h0000, 0, 0, "R1 zero inside");
        step(1, 16'hFF00, 0, 0, "R1 FF00 inside");
        step(1, 16'hFF01, 0, 0, "R1 FF01 outside");
        step(0, 16'h0000, 1, 0, "R6 write clear");

        // R2: strict edges with 40h/10h.
        thr_hi_i = 8'h40; thr_lo_i = 8'h10; persist_sel_i = 2'd0;
        step(1, 16'h4000, 0, 0, "R2 equal upper inside");
        step(1, 16'h1000, 0, 0, "R2 equal lower inside");
        step(1, 16'h0FFF, 0, 0, "R2 below lower fires");
        step(1, 16'h2000, 0, 0, "R5 inside keeps flag");
        idle("R5 idle keeps flag");
        step(0, 16'h0, 0, 1, "R6 command clear");
        step(1, 16'h4001, 0, 0, "R2 above upper fires");
        step(0, 16'h0, 1, 1, "R6 both clears");

        // R3/R4 with run of 4.
        persist_sel_i = 2'd1;
        for (int i = 0; i < 3; i++) step(1, 16'h5000, 0, 0, "R3 short run no flag");
        step(1, 16'h2000, 0, 0, "R4 inside restarts");
        for (int i = 0; i < 3; i++) step(1, 16'h0100, 0, 0, "R4 after restart no flag");
        idle("R4 idle holds count");
        step(0, 16'h0, 0, 0, "R4 idle holds count");
        step(1, 16'h0100, 0, 0, "R3 fourth reading fires");

        // R7: trigger and clear together while count is stopped at limit.
        step(1, 16'h0100, 1, 0, "R7 trigger beats write clear");
        step(1, 16'h0100, 0, 1, "R7 trigger beats command clear");
        // R9: clear then one more outside reading re-fires.
        step(0, 16'h0, 1, 0, "R6 clear at saturation");
        step(1, 16'h7000, 0, 0, "R9 saturated run re-fires");
        step(1, 16'h2000, 0, 1, "R6 clear with inside reading");

        // R3 run of 8.
        persist_sel_i = 2'd2;
        for (int i = 0; i < 7; i++) step(1, 16'hF000, 0, 0, "R3 run of 8 pending");
        step(1, 16'hF000, 0, 0, "R3 run of 8 fires");
        step(1, 16'h3000, 1, 0, "R6 clear");

        // R3 run of 16.
        persist_sel_i = 2'd3;
        for (int i = 0; i < 15; i++) step(1, 16'h0000, 0, 0, "R3 run of 16 pending");
        step(1, 16'h0000, 0, 0, "R3 run of 16 fires");
        step(1, 16'h3000, 0, 0, "R5 held after run");
        idle("R8 pad follows flag");
        idle("drain");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule